// File: doc/BRIEF.md
# Power Distribution State Controller

This block is the central mode controller of a power distribution unit. It turns single-cycle pulses into tap operations, network broadcast requests and a power-bus disconnect. The pulses come from the console buttons and the mains switch, and from two network callbacks: one in which the control PC asks for a full power-down, and one in which the motion PC asks to stop the motor drives. The actual tap switching is done elsewhere by a tap sequencer. This controller issues one operation code per cycle to that sequencer and, for the operations that take time, waits until the sequencer reports completion.

The controller has six stable modes: mains down, standby, running, halted, motion hold and emergency. The two callback kinds wait in a small ordered queue. The queue keeps at most one entry of each kind, so it never holds more than two entries. Entries are served in arrival order, one per cycle, and only in a cycle with no console or mains pulse and no tap operation in progress. Any command or callback that a mode does not define leaves the controller unchanged.

Top module: `pdu_state_ctrl`

## Requirements
- R1: After reset the mode is mains down (`state_o` = 0), no tap operation is issued (`tap_op_o` = 0), and `busy_o`, `shutdown_o`, `restart_o` and `bus_disconnect_o` are low. The mode codes are: mains down 0, standby 1, running 2, halted 3, motion hold 4, emergency 5.
- R2: A mains-up pulse in mains down enters standby and issues op 1, which powers the permanent taps. A mains-down pulse in any other mode enters mains down and issues op 8, which cuts every tap at once. A mains-down pulse is accepted even while `busy_o` is high, and it clears `busy_o`.
- R3: A power-on pulse has a different effect in each mode. In standby it enters running and issues op 2, which ramps up the switchable taps. In running it pulses `restart_o` and stays in running. In halted or emergency it enters running and issues op 5, which ramps up all taps. In motion hold it enters running and issues op 6, which restores the motor taps.
- R4: A power-off pulse in running or motion hold enters standby, pulses `shutdown_o` with `shutdown_incl_ctrl_o` low, and issues op 3, an orderly switch-off of the switchable taps.
- R5: A forced-off pulse in standby, running or motion hold enters halted and issues op 8.
- R6: A control-PC power-off callback served in standby, running or motion hold enters halted, pulses `shutdown_o` with `shutdown_incl_ctrl_o` high, and issues op 4, an orderly switch-off of all taps.
- R7: A stop callback served in running enters motion hold and issues op 7, which cuts the motor taps.
- R8: An emergency pulse in any mode other than mains down enters emergency and issues no tap operation. It is accepted even while busy and clears `busy_o`. `bus_disconnect_o` is high exactly while the mode is emergency.
- R9: A console or mains pulse that the current mode does not define changes neither the mode nor any output.
- R10: A callback that the current mode does not define is removed from the queue with no effect, and it is not applied later in another mode.
- R11: The queue holds at most one entry of each callback kind, and a second arrival of a kind already held is dropped. Entries are served in arrival order. When both kinds arrive in the same cycle, stop is treated as older.
- R12: Ops 1 to 6 raise `busy_o` until a `seq_done_i` pulse. While busy, console pulses other than emergency and mains-down are dropped, and queued callbacks wait. When several pulses arrive in the same cycle, only one is acted on, in this priority order: mains-down, emergency, forced-off, power-off, power-on, mains-up.
- R13: A callback is served no earlier than the cycle after it arrives, at most one per cycle, and never in a cycle that carries any console or mains pulse.
- R14: `tap_op_o`, `shutdown_o` and `restart_o` are single-cycle pulses, and `shutdown_o` and `restart_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_on_i | input | 1 | Power-on console pulse |
| pwr_off_i | input | 1 | Orderly power-off console pulse |
| force_off_i | input | 1 | Forced power-off console pulse |
| emerg_off_i | input | 1 | Emergency-off pulse |
| mains_up_i | input | 1 | Mains switch closed pulse |
| mains_down_i | input | 1 | Mains switch opened pulse |
| cb_stop_i | input | 1 | Motion-stop callback arrival |
| cb_ctrl_off_i | input | 1 | Control-PC power-off callback arrival |
| seq_done_i | input | 1 | Tap sequencer completion pulse |
| tap_op_o | output | TAP_W | Tap operation code, 0 means none |
| shutdown_o | output | 1 | Shutdown broadcast request pulse |
| restart_o | output | 1 | Restart broadcast request pulse |
| shutdown_incl_ctrl_o | output | 1 | Shutdown also addresses the control PC |
| bus_disconnect_o | output | 1 | Internal power bus and UPS disconnected |
| busy_o | output | 1 | Tap operation awaiting completion |
| state_o | output | 3 | Current mode code |

## Verification
The checker watches several cycle-level relations on every cycle. Broadcast pulses are never high together, and the control-PC flag never appears without a shutdown. Every entry into standby, motion hold or emergency has the right cause. Only the immediate all-cut op can appear while busy, and every mains-down pulse forces the mains-down mode. Queue ordering, duplicate dropping, consumption of undefined callbacks and callbacks being held back by a console pulse all depend on history across several cycles, so only the bench scenarios show them, by observing the mode and op codes in the cycles after each callback.

// File: rtl/pdu_ctrl_pkg.sv
package pdu_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_MAINS_DOWN  = 3'd0,
      ST_STANDBY     = 3'd1,
      ST_RUN         = 3'd2,
      ST_HALTED      = 3'd3,
      ST_MOTION_HOLD = 3'd4,
      ST_EMERGENCY   = 3'd5
   } pdu_state_e;

   typedef enum logic [3:0] {
      TAP_NONE        = 4'd0,
      TAP_PERM_UP     = 4'd1,
      TAP_SW_RAMP_UP  = 4'd2,
      TAP_SW_DRAIN    = 4'd3,
      TAP_ALL_DRAIN   = 4'd4,
      TAP_ALL_RAMP_UP = 4'd5,
      TAP_MOTOR_UP    = 4'd6,
      TAP_MOTOR_CUT   = 4'd7,
      TAP_ALL_CUT     = 4'd8
   } tap_op_e;

   typedef enum logic [2:0] {
      UC_NONE,
      UC_MAINS_DOWN,
      UC_EMERG,
      UC_FORCE,
      UC_OFF,
      UC_ON,
      UC_MAINS_UP
   } ucmd_e;

   typedef enum logic {
      CB_STOP     = 1'b0,
      CB_CTRL_OFF = 1'b1
   } cb_kind_e;

   typedef struct packed {
      logic pwr_on;
      logic pwr_off;
      logic force_off;
      logic emerg_off;
      logic mains_up;
      logic mains_down;
   } user_cmd_t;

   localparam int unsigned OP_NATIVE_W = 4;

   // operations that take time and are acknowledged by the sequencer
   function automatic logic op_needs_done(tap_op_e op);
      return (op != TAP_NONE) && (op < TAP_MOTOR_CUT);
   endfunction

endpackage

// File: rtl/pdu_cmd_select.sv
module pdu_cmd_select
   import pdu_ctrl_pkg::*;
(
   input  user_cmd_t cmd_i,
   output ucmd_e     sel_o,
   output logic      any_o
);
   always_comb begin
      sel_o = UC_NONE;
      if (cmd_i.mains_down)     sel_o = UC_MAINS_DOWN;
      else if (cmd_i.emerg_off) sel_o = UC_EMERG;
      else if (cmd_i.force_off) sel_o = UC_FORCE;
      else if (cmd_i.pwr_off)   sel_o = UC_OFF;
      else if (cmd_i.pwr_on)    sel_o = UC_ON;
      else if (cmd_i.mains_up)  sel_o = UC_MAINS_UP;
   end

   assign any_o = |cmd_i;
endmodule

// File: rtl/pdu_cb_queue.sv
module pdu_cb_queue
   import pdu_ctrl_pkg::*;
#(
   parameter bit TIE_STOP_FIRST = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     push_stop_i,
   input  logic     push_ctrl_i,
   input  logic     pop_i,
   output logic     head_valid_o,
   output cb_kind_e head_kind_o
);
   logic has_stop_q, has_ctrl_q, ctrl_older_q;
   logic head_is_ctrl, pop_stop, pop_ctrl;
   logic stop_kept, ctrl_kept, stop_new, ctrl_new;
   logic tie_ctrl_first, n_older;

   generate
      if (TIE_STOP_FIRST) begin : g_tie_stop
         assign tie_ctrl_first = 1'b0;
      end else begin : g_tie_ctrl
         assign tie_ctrl_first = 1'b1;
      end
   endgenerate

   assign head_is_ctrl = has_ctrl_q & (~has_stop_q | ctrl_older_q);
   assign head_valid_o = has_stop_q | has_ctrl_q;
   assign head_kind_o  = head_is_ctrl ? CB_CTRL_OFF : CB_STOP;

   assign pop_stop  = pop_i & has_stop_q & ~head_is_ctrl;
   assign pop_ctrl  = pop_i & head_is_ctrl;
   assign stop_kept = has_stop_q & ~pop_stop;
   assign ctrl_kept = has_ctrl_q & ~pop_ctrl;
   assign stop_new  = push_stop_i & ~has_stop_q;
   assign ctrl_new  = push_ctrl_i & ~has_ctrl_q;

   always_comb begin
      if (ctrl_kept)      n_older = stop_kept ? ctrl_older_q : 1'b1;
      else if (stop_kept) n_older = 1'b0;
      else                n_older = tie_ctrl_first;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         has_stop_q   <= 1'b0;
         has_ctrl_q   <= 1'b0;
         ctrl_older_q <= 1'b0;
      end else begin
         has_stop_q   <= stop_kept | stop_new;
         has_ctrl_q   <= ctrl_kept | ctrl_new;
         ctrl_older_q <= n_older;
      end
   end
endmodule

// File: rtl/pdu_mode_fsm.sv
module pdu_mode_fsm
   import pdu_ctrl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  ucmd_e      ucmd_i,
   input  logic       any_cmd_i,
   input  logic       head_valid_i,
   input  cb_kind_e   head_kind_i,
   input  logic       seq_done_i,
   output logic       pop_o,
   output pdu_state_e state_o,
   output tap_op_e    tap_op_o,
   output logic       shutdown_o,
   output logic       restart_o,
   output logic       incl_ctrl_o,
   output logic       busy_o
);
   pdu_state_e state_q, n_state;
   tap_op_e    tap_q, n_tap;
   logic       sd_q, rs_q, incl_q, busy_q;
   logic       n_sd, n_rs, n_incl, n_busy, kill_busy;

   assign pop_o = head_valid_i & ~any_cmd_i & ~busy_q;

   always_comb begin
      n_state   = state_q;
      n_tap     = TAP_NONE;
      n_sd      = 1'b0;
      n_rs      = 1'b0;
      n_incl    = 1'b0;
      kill_busy = 1'b0;
      if (ucmd_i == UC_MAINS_DOWN) begin
         if (state_q != ST_MAINS_DOWN) begin
            n_state   = ST_MAINS_DOWN;
            n_tap     = TAP_ALL_CUT;
            kill_busy = 1'b1;
         end
      end else if (ucmd_i == UC_EMERG) begin
         if (state_q != ST_MAINS_DOWN && state_q != ST_EMERGENCY) begin
            n_state   = ST_EMERGENCY;
            kill_busy = 1'b1;
         end
      end else if (ucmd_i != UC_NONE) begin
         if (!busy_q) begin
            case (state_q)
               ST_MAINS_DOWN: if (ucmd_i == UC_MAINS_UP) begin
                  n_state = ST_STANDBY;  n_tap = TAP_PERM_UP;
               end
               ST_STANDBY: begin
                  if (ucmd_i == UC_ON) begin
                     n_state = ST_RUN;   n_tap = TAP_SW_RAMP_UP;
                  end else if (ucmd_i == UC_FORCE) begin
                     n_state = ST_HALTED; n_tap = TAP_ALL_CUT;
                  end
               end
               ST_RUN, ST_MOTION_HOLD: begin
                  if (ucmd_i == UC_ON) begin
                     if (state_q == ST_RUN) n_rs = 1'b1;
                     else begin
                        n_state = ST_RUN; n_tap = TAP_MOTOR_UP;
                     end
                  end else if (ucmd_i == UC_OFF) begin
                     n_state = ST_STANDBY; n_tap = TAP_SW_DRAIN; n_sd = 1'b1;
                  end else if (ucmd_i == UC_FORCE) begin
                     n_state = ST_HALTED;  n_tap = TAP_ALL_CUT;
                  end
               end
               ST_HALTED, ST_EMERGENCY: if (ucmd_i == UC_ON) begin
                  n_state = ST_RUN;      n_tap = TAP_ALL_RAMP_UP;
               end
               default: ;
            endcase
         end
      end else if (pop_o) begin
         if (head_kind_i == CB_CTRL_OFF) begin
            if (state_q == ST_STANDBY || state_q == ST_RUN ||
                state_q == ST_MOTION_HOLD) begin
               n_state = ST_HALTED; n_tap = TAP_ALL_DRAIN;
               n_sd    = 1'b1;      n_incl = 1'b1;
            end
         end else if (state_q == ST_RUN) begin
            n_state = ST_MOTION_HOLD; n_tap = TAP_MOTOR_CUT;
         end
      end
   end

   always_comb begin
      if (kill_busy)                 n_busy = 1'b0;
      else if (op_needs_done(n_tap)) n_busy = 1'b1;
      else if (seq_done_i)           n_busy = 1'b0;
      else                           n_busy = busy_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_MAINS_DOWN;
         tap_q   <= TAP_NONE;
         sd_q    <= 1'b0;
         rs_q    <= 1'b0;
         incl_q  <= 1'b0;
         busy_q  <= 1'b0;
      end else begin
         state_q <= n_state;
         tap_q   <= n_tap;
         sd_q    <= n_sd;
         rs_q    <= n_rs;
         incl_q  <= n_incl;
         busy_q  <= n_busy;
      end
   end

   assign state_o     = state_q;
   assign tap_op_o    = tap_q;
   assign shutdown_o  = sd_q;
   assign restart_o   = rs_q;
   assign incl_ctrl_o = incl_q;
   assign busy_o      = busy_q;
endmodule

// File: rtl/pdu_state_ctrl.sv
module pdu_state_ctrl
   import pdu_ctrl_pkg::*;
#(
   parameter int unsigned TAP_W          = 4,
   parameter bit          TIE_STOP_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_on_i,
   input  logic             pwr_off_i,
   input  logic             force_off_i,
   input  logic             emerg_off_i,
   input  logic             mains_up_i,
   input  logic             mains_down_i,
   input  logic             cb_stop_i,
   input  logic             cb_ctrl_off_i,
   input  logic             seq_done_i,
   output logic [TAP_W-1:0] tap_op_o,
   output logic             shutdown_o,
   output logic             restart_o,
   output logic             shutdown_incl_ctrl_o,
   output logic             bus_disconnect_o,
   output logic             busy_o,
   output logic [2:0]       state_o
);
   localparam int unsigned PAD_W = TAP_W - OP_NATIVE_W;

   generate
      if (TAP_W < OP_NATIVE_W) begin : g_bad_tap_w
         $error("TAP_W too narrow for the tap operation codes");
      end
   endgenerate

   user_cmd_t  cmd;
   ucmd_e      ucmd;
   logic       any_cmd, pop, head_valid;
   cb_kind_e   head_kind;
   pdu_state_e mode;
   tap_op_e    op;

   assign cmd = '{pwr_on: pwr_on_i, pwr_off: pwr_off_i, force_off: force_off_i,
                  emerg_off: emerg_off_i, mains_up: mains_up_i,
                  mains_down: mains_down_i};

   pdu_cmd_select u_sel (
      .cmd_i (cmd),
      .sel_o (ucmd),
      .any_o (any_cmd)
   );

   pdu_cb_queue #(.TIE_STOP_FIRST(TIE_STOP_FIRST)) u_queue (
      .clk          (clk),
      .rst_n        (rst_n),
      .push_stop_i  (cb_stop_i),
      .push_ctrl_i  (cb_ctrl_off_i),
      .pop_i        (pop),
      .head_valid_o (head_valid),
      .head_kind_o  (head_kind)
   );

   pdu_mode_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .ucmd_i       (ucmd),
      .any_cmd_i    (any_cmd),
      .head_valid_i (head_valid),
      .head_kind_i  (head_kind),
      .seq_done_i   (seq_done_i),
      .pop_o        (pop),
      .state_o      (mode),
      .tap_op_o     (op),
      .shutdown_o   (shutdown_o),
      .restart_o    (restart_o),
      .incl_ctrl_o  (shutdown_incl_ctrl_o),
      .busy_o       (busy_o)
   );

   generate
      if (PAD_W == 0) begin : g_op_exact
         assign tap_op_o = op;
      end else begin : g_op_pad
         assign tap_op_o = {{PAD_W{1'b0}}, op};
      end
   endgenerate

   assign state_o          = mode;
   assign bus_disconnect_o = (mode == ST_EMERGENCY);
endmodule

// File: rtl/pdu_state_ctrl_chk.sv
module pdu_state_ctrl_chk #(
   parameter int unsigned TAP_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             emerg_off_i,
   input logic             mains_up_i,
   input logic             mains_down_i,
   input logic [TAP_W-1:0] tap_op_o,
   input logic             shutdown_o,
   input logic             restart_o,
   input logic             shutdown_incl_ctrl_o,
   input logic             bus_disconnect_o,
   input logic             busy_o,
   input logic [2:0]       state_o
);
   // R14
   bcast_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(shutdown_o && restart_o));

   // R6
   incl_with_sd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_incl_ctrl_o |-> shutdown_o);

   // R8
   emerg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_disconnect_o) |-> $past(emerg_off_i));

   // R2
   mains_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mains_down_i) |-> state_o == 3'd0);

   // R2
   standby_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd1 && $past(state_o) == 3'd0) |-> $past(mains_up_i));

   // R12
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy_o) && tap_op_o != '0) |-> tap_op_o == TAP_W'(8));

   // R3
   restart_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_o |-> (state_o == 3'd2 && $past(state_o) == 3'd2));

   // R7
   hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd4 && $past(state_o) != 3'd4) |-> tap_op_o == TAP_W'(7));
endmodule

bind pdu_state_ctrl pdu_state_ctrl_chk #(.TAP_W(TAP_W)) u_chk (
   .clk                  (clk),
   .rst_n                (rst_n),
   .emerg_off_i          (emerg_off_i),
   .mains_up_i           (mains_up_i),
   .mains_down_i         (mains_down_i),
   .tap_op_o             (tap_op_o),
   .shutdown_o           (shutdown_o),
   .restart_o            (restart_o),
   .shutdown_incl_ctrl_o (shutdown_incl_ctrl_o),
   .bus_disconnect_o     (bus_disconnect_o),
   .busy_o               (busy_o),
   .state_o              (state_o)
);

// File: tb/test_pdu_state_ctrl.sv
module test_pdu_state_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_on_i = 0, pwr_off_i = 0, force_off_i = 0, emerg_off_i = 0;
   logic mains_up_i = 0, mains_down_i = 0, cb_stop_i = 0, cb_ctrl_off_i = 0;
   logic seq_done_i = 0;
   logic [3:0] tap_op_o;
   logic shutdown_o, restart_o, shutdown_incl_ctrl_o, bus_disconnect_o, busy_o;
   logic [2:0] state_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pdu_state_ctrl i_pdu_state_ctrl (
      .clk(clk), .rst_n(rst_n),
      .pwr_on_i(pwr_on_i), .pwr_off_i(pwr_off_i), .force_off_i(force_off_i),
      .emerg_off_i(emerg_off_i), .mains_up_i(mains_up_i),
      .mains_down_i(mains_down_i), .cb_stop_i(cb_stop_i),
      .cb_ctrl_off_i(cb_ctrl_off_i), .seq_done_i(seq_done_i),
      .tap_op_o(tap_op_o), .shutdown_o(shutdown_o), .restart_o(restart_o),
      .shutdown_incl_ctrl_o(shutdown_incl_ctrl_o),
      .bus_disconnect_o(bus_disconnect_o), .busy_o(busy_o), .state_o(state_o)
   );

   // stimulus codes: 0 on, 1 off, 2 force, 3 emerg, 4 mains up,
   // 5 mains down, 6 ctrl callback, 7 stop callback
   // fields: stim[15:12] state[11:9] tap[8:5] sd[4] rs[3] incl[2] bus[1] 0
   localparam int NV = 30;
   localparam logic [15:0] VEC [0:NV-1] = '{
      {4'd4, 3'd1, 4'd1, 5'b00000},
      {4'd1, 3'd1, 4'd0, 5'b00000},
      {4'd0, 3'd2, 4'd2, 5'b00000},
      {4'd0, 3'd2, 4'd0, 5'b01000},
      {4'd7, 3'd4, 4'd7, 5'b00000},
      {4'd7, 3'd4, 4'd0, 5'b00000},
      {4'd0, 3'd2, 4'd6, 5'b00000},
      {4'd1, 3'd1, 4'd3, 5'b10000},
      {4'd6, 3'd3, 4'd4, 5'b10100},
      {4'd0, 3'd2, 4'd5, 5'b00000},
      {4'd2, 3'd3, 4'd8, 5'b00000},
      {4'd0, 3'd2, 4'd5, 5'b00000},
      {4'd7, 3'd4, 4'd7, 5'b00000},
      {4'd2, 3'd3, 4'd8, 5'b00000},
      {4'd0, 3'd2, 4'd5, 5'b00000},
      {4'd3, 3'd5, 4'd0, 5'b00010},
      {4'd4, 3'd5, 4'd0, 5'b00010},
      {4'd0, 3'd2, 4'd5, 5'b00000},
      {4'd7, 3'd4, 4'd7, 5'b00000},
      {4'd6, 3'd3, 4'd4, 5'b10100},
      {4'd5, 3'd0, 4'd8, 5'b00000},
      {4'd0, 3'd0, 4'd0, 5'b00000},
      {4'd4, 3'd1, 4'd1, 5'b00000},
      {4'd0, 3'd2, 4'd2, 5'b00000},
      {4'd6, 3'd3, 4'd4, 5'b10100},
      {4'd0, 3'd2, 4'd5, 5'b00000},
      {4'd7, 3'd4, 4'd7, 5'b00000},
      {4'd1, 3'd1, 4'd3, 5'b10000},
      {4'd2, 3'd3, 4'd8, 5'b00000},
      {4'd1, 3'd3, 4'd0, 5'b00000}
   };

   function automatic string req_of(logic [3:0] s, bit ignored);
      if (ignored) return (s >= 6) ? "R10" : "R9";
      case (s)
         4'd0: return "R3";
         4'd1: return "R4";
         4'd2: return "R5";
         4'd3: return "R8";
         4'd6: return "R6";
         4'd7: return "R7";
         default: return "R2";
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] snap();
      return {state_o, tap_op_o, shutdown_o, restart_o, shutdown_incl_ctrl_o,
              bus_disconnect_o, 1'b0};
   endfunction

   task automatic apply(logic [3:0] s);
      case (s)
         4'd0: pwr_on_i = 1;
         4'd1: pwr_off_i = 1;
         4'd2: force_off_i = 1;
         4'd3: emerg_off_i = 1;
         4'd4: mains_up_i = 1;
         4'd5: mains_down_i = 1;
         4'd6: cb_ctrl_off_i = 1;
         default: cb_stop_i = 1;
      endcase
      @(negedge clk);
      {pwr_on_i, pwr_off_i, force_off_i, emerg_off_i} = '0;
      {mains_up_i, mains_down_i, cb_ctrl_off_i, cb_stop_i} = '0;
      if (s >= 6) @(negedge clk);
   endtask

   task automatic push_cb(logic [3:0] s);
      if (s == 4'd6) cb_ctrl_off_i = 1; else cb_stop_i = 1;
      @(negedge clk);
      cb_ctrl_off_i = 0;
      cb_stop_i = 0;
   endtask

   task automatic finish_seq();
      seq_done_i = 1;
      @(negedge clk);
      seq_done_i = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [2:0] prev_state;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset values
      chk("R1", {20'd0, snap()}, 32'd0);
      chk("R1", {31'd0, busy_o}, 32'd0);

      prev_state = 3'd0;
      for (int i = 0; i < NV; i++) begin
         bit ign;
         apply(VEC[i][15:12]);
         ign = (VEC[i][11:9] == prev_state) && (VEC[i][8:3] == 6'd0);
         chk(req_of(VEC[i][15:12], ign), {20'd0, snap()}, {20'd0, VEC[i][11:0]});
         prev_state = VEC[i][11:9];
         if (VEC[i][8:5] >= 4'd1 && VEC[i][8:5] <= 4'd6) begin
            chk("R12", {31'd0, busy_o}, 32'd1);
            finish_seq();
         end
      end

      // R12: commands dropped and callbacks held while busy; R11 duplicates
      apply(4'd0);                                   // halted -> run, op 5
      chk("R12", {31'd0, busy_o}, 32'd1);
      apply(4'd1);
      chk("R12", {20'd0, snap()}, {20'd0, 3'd2, 9'd0});
      push_cb(4'd7);
      @(negedge clk);
      chk("R12", {29'd0, state_o}, 32'd2);
      push_cb(4'd7);
      finish_seq();
      @(negedge clk);
      chk("R11", {20'd0, snap()}, {20'd0, 3'd4, 4'd7, 5'b0});
      apply(4'd0);                                   // hold -> run, op 6
      finish_seq();
      repeat (3) @(negedge clk);
      chk("R11", {29'd0, state_o}, 32'd2);

      // R11 order ctrl before stop; R10 stop consumed in halted
      apply(4'd2);
      apply(4'd0);
      push_cb(4'd6);
      push_cb(4'd7);
      finish_seq();
      @(negedge clk);
      chk("R11", {20'd0, snap()}, {20'd0, 3'd3, 4'd4, 5'b10100});
      finish_seq();
      @(negedge clk);
      chk("R10", {20'd0, snap()}, {20'd0, 3'd3, 9'd0});
      apply(4'd0);
      finish_seq();
      repeat (3) @(negedge clk);
      chk("R10", {29'd0, state_o}, 32'd2);

      // R11 order stop before ctrl, R13 one per cycle
      apply(4'd2);
      apply(4'd0);
      push_cb(4'd7);
      push_cb(4'd6);
      finish_seq();
      @(negedge clk);
      chk("R13", {20'd0, snap()}, {20'd0, 3'd4, 4'd7, 5'b0});
      @(negedge clk);
      chk("R13", {20'd0, snap()}, {20'd0, 3'd3, 4'd4, 5'b10100});
      finish_seq();

      // R13 console pulse delays a queued callback
      apply(4'd0);
      finish_seq();
      cb_stop_i = 1;
      @(negedge clk);
      cb_stop_i = 0;
      pwr_on_i = 1;
      @(negedge clk);
      pwr_on_i = 0;
      chk("R13", {20'd0, snap()}, {20'd0, 3'd2, 4'd0, 5'b01000});
      @(negedge clk);
      chk("R13", {20'd0, snap()}, {20'd0, 3'd4, 4'd7, 5'b0});

      // R8 emergency and R2 mains down accepted while busy
      apply(4'd0);
      chk("R12", {31'd0, busy_o}, 32'd1);
      apply(4'd3);
      chk("R8", {19'd0, busy_o, snap()}, {19'd0, 1'b0, 3'd5, 9'd2});
      apply(4'd0);
      apply(4'd5);
      chk("R2", {19'd0, busy_o, snap()}, {19'd0, 1'b0, 3'd0, 4'd8, 5'b0});

      // R9 emergency ignored in mains down
      apply(4'd3);
      chk("R9", {20'd0, snap()}, 32'd0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule